// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the program order of instructions in a speculative out-of-order core. Each instruction takes an entry at dispatch, and that entry's index becomes the destination tag the reservation stations wait on. Functional units broadcast results on a shared result bus, tagged with that index. The buffer captures each result into its entry. The oldest entry retires once its result has arrived. An ALU entry writes the architectural register file. A store entry releases the store to memory. A correctly predicted branch simply leaves the buffer. A branch that reaches the head with its mispredict flag set empties the whole buffer in one cycle.

Dispatch is a valid/ready stream. An instruction is taken on a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` falls when any of these holds: no reservation station is free (`rs_avail` low), the buffer is full and nothing retires that cycle, or a flush is under way. The source must hold its request until it is taken. The result bus and the commit outputs are broadcasts with no back-pressure. The register file and store queue take a commit on the cycle it is shown.

The buffer holds eight entries, and its pointers carry a wrap bit. Kind codes on `disp_kind`: 0 = ALU, 1 = store, 2 = branch, 3 = handled like ALU.

Top module: `spec_rob`

## Requirements
- R1: Out of reset the buffer is empty: `disp_tag` is 0, `disp_ready` equals `rs_avail`, and `rf_we`, `st_go` and `flush` are low.
- R2: A dispatch is taken when `disp_valid`, `disp_ready` and `rs_avail` are high. `disp_tag` shows the entry it receives. Successive dispatches receive tags 0,1,...,7,0,... .
- R3: With eight entries occupied and no retirement in the cycle, `disp_ready` is low and no entry is allocated.
- R4: On a full buffer whose head retires in the same cycle, `disp_ready` is high and the dispatch is taken into the slot just freed.
- R5: A broadcast (`cdb_valid`, `cdb_tag`, `cdb_value`, `cdb_mispredict`) to an occupied entry that has no result yet stores the value and marks the entry ready. A broadcast to a free entry, or to an entry that already holds a result, has no effect.
- R6: Entries retire strictly in allocation order. The head retires only once its result is present, and younger ready entries wait behind it.
- R7: When an ready ALU entry is at the head, `rf_we` is high in that same cycle, with `rf_addr` set to its destination register and `rf_data` set to its value. The entry is freed at the next edge.
- R8: When a ready store entry is at the head, `st_go` is high and `st_tag` gives its tag, with `rf_we` low. At most one of `rf_we`, `st_go` and `flush` is high in any cycle.
- R9: When a ready branch without the mispredict flag is at the head, it retires with `rf_we`, `st_go` and `flush` all low.
- R10: When a ready branch with the mispredict flag set is at the head, `flush` is high for that cycle and `disp_ready` is low. After the next edge the buffer is empty, the next tag is 0, and broadcasts to the discarded tags are ignored.
- R11: While `rs_avail` is low, `disp_ready` is low and no tag is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rs_avail | input | 1 | A reservation station is free |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Dispatch can be taken this cycle |
| disp_kind | input | 2 | Instruction kind (0 ALU, 1 store, 2 branch) |
| disp_dest | input | 5 | Destination architectural register |
| disp_tag | output | 3 | Tag handed to the dispatched instruction |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 3 | Entry the broadcast belongs to |
| cdb_value | input | 32 | Broadcast result value |
| cdb_mispredict | input | 1 | Branch outcome was mispredicted |
| rf_we | output | 1 | Register file write on commit |
| rf_addr | output | 5 | Register written on commit |
| rf_data | output | 32 | Value written on commit |
| st_go | output | 1 | Release the store in entry `st_tag` |
| st_tag | output | 3 | Tag of the store being released |
| flush | output | 1 | Mispredicted branch at head, buffer discarded |

## Verification
Commit and flush outputs are combinational decodes of the registered head entry. A result broadcast sampled at edge k therefore appears on `rf_we`, `st_go` or `flush` in the cycle that follows edge k, provided that entry is at the head. The freed entry and the moved pointer take effect at edge k+1. `disp_ready` and `disp_tag` answer in the same cycle as the request, and a flush or full condition is reflected on `disp_ready` in the cycle it exists. The bench keeps a behavioural model that is updated at each rising edge. It compares every output shortly after the falling edge, once all inputs for that cycle are settled, so each comparison falls in the exact cycle where the result is due.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    OP_ALU    = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2,
    OP_SPARE  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [TAG_W-1:0] head_idx,
  output logic [TAG_W-1:0] tail_idx,
  output logic             full
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [PTR_W-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc)  tail_q <= tail_q + 1'b1;
      if (retire) head_q <= head_q + 1'b1;
    end
  end

  assign head_idx = head_q[TAG_W-1:0];
  assign tail_idx = tail_q[TAG_W-1:0];
  assign full     = (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]) &&
                    (head_q[TAG_W] != tail_q[TAG_W]);
  assign occ      = tail_q - head_q;

  // R3: occupancy never exceeds the number of entries
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));

  // R6: each retirement moves the head by exactly one
  p_head_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !flush) |=> head_q == PTR_W'($past(head_q) + 1'b1));

  // R10: after a flush both pointers are back at zero
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (head_q == '0 && tail_q == '0));
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [TAG_W-1:0]  tail_idx,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_misp,
  input  logic              retire,
  input  logic              flush,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              head_valid,
  output logic              head_ready,
  output logic [1:0]        head_kind,
  output logic [REG_W-1:0]  head_dest,
  output logic [DATA_W-1:0] head_value,
  output logic              head_misp
);
  logic [DEPTH-1:0]  valid_q, ready_q, hit, take;
  logic [1:0]        kind_q  [DEPTH];
  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic              misp_q  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign take[i] = alloc && (tail_idx == TAG_W'(i));
    assign hit[i]  = cdb_valid && !flush && valid_q[i] && !ready_q[i] &&
                     (cdb_tag == TAG_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ready_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
      ready_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (take[i]) begin
          valid_q[i] <= 1'b1;
          ready_q[i] <= 1'b0;
        end else begin
          if (hit[i]) ready_q[i] <= 1'b1;
          if (retire && head_idx == TAG_W'(i)) valid_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (take[i]) begin
        kind_q[i] <= alloc_kind;
        dest_q[i] <= alloc_dest;
        misp_q[i] <= 1'b0;
      end else if (hit[i]) begin
        value_q[i] <= cdb_value;
        misp_q[i]  <= cdb_misp;
      end
    end
  end

  assign head_valid = valid_q[head_idx];
  assign head_ready = ready_q[head_idx];
  assign head_kind  = kind_q[head_idx];
  assign head_dest  = dest_q[head_idx];
  assign head_value = value_q[head_idx];
  assign head_misp  = misp_q[head_idx];

  // R5: a capture leaves the addressed entry ready
  p_capture_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && !flush && valid_q[cdb_tag] && !ready_q[cdb_tag])
      |=> ready_q[$past(cdb_tag)]);

  // R5: a second broadcast does not overwrite a held result
  p_dup_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && !flush && valid_q[cdb_tag] && ready_q[cdb_tag] &&
     !(alloc && tail_idx == cdb_tag))
      |=> value_q[$past(cdb_tag)] == $past(value_q[cdb_tag]));
endmodule

// File: rtl/rob_retire_unit.sv
module rob_retire_unit
  import spec_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic              head_ready,
  input  logic [1:0]        head_kind,
  input  logic [REG_W-1:0]  head_dest,
  input  logic [DATA_W-1:0] head_value,
  input  logic              head_misp,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              retire,
  output logic              flush,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_go,
  output logic [TAG_W-1:0]  st_tag
);
  op_kind_e kind;
  logic     done;

  always_comb begin
    kind   = op_kind_e'(head_kind);
    done   = head_valid && head_ready;
    flush  = 1'b0;
    rf_we  = 1'b0;
    st_go  = 1'b0;
    unique case (kind)
      OP_STORE:  st_go = done;
      OP_BRANCH: flush = done && head_misp;
      default:   rf_we = done;
    endcase
    retire = done && !flush;
  end

  assign rf_addr = head_dest;
  assign rf_data = head_value;
  assign st_tag  = head_idx;

  // R8: never more than one commit action at a time
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_go, flush}));
endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH = 8,
  parameter int REG_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_avail,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [1:0]        disp_kind,
  input  logic [REG_W-1:0]  disp_dest,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispredict,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_go,
  output logic [TAG_W-1:0]  st_tag,
  output logic              flush
);
  logic [TAG_W-1:0]  head_idx, tail_idx;
  logic              full, alloc, retire;
  logic              h_valid, h_ready, h_misp;
  logic [1:0]        h_kind;
  logic [REG_W-1:0]  h_dest;
  logic [DATA_W-1:0] h_value;

  assign disp_ready = rs_avail && !flush && (!full || retire);
  assign alloc      = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full)
  );

  rob_entry_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .tail_idx(tail_idx),
    .alloc_kind(disp_kind), .alloc_dest(disp_dest),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .cdb_misp(cdb_mispredict), .retire(retire), .flush(flush),
    .head_idx(head_idx), .head_valid(h_valid), .head_ready(h_ready),
    .head_kind(h_kind), .head_dest(h_dest), .head_value(h_value),
    .head_misp(h_misp)
  );

  rob_retire_unit #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_retire (
    .clk(clk), .rst_n(rst_n), .head_valid(h_valid), .head_ready(h_ready),
    .head_kind(h_kind), .head_dest(h_dest), .head_value(h_value),
    .head_misp(h_misp), .head_idx(head_idx), .retire(retire), .flush(flush),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_go(st_go), .st_tag(st_tag)
  );

  // R4: a full buffer that retires still accepts a dispatch
  p_full_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && retire && rs_avail) |-> disp_ready);

  // R11: no allocation without a free reservation station
  p_rs_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_avail |=> disp_tag == $past(disp_tag) || $past(flush));
endmodule

// File: tb/tb_spec_rob.sv
`timescale 1ns/100ps
module tb_spec_rob;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rs_avail, disp_valid, disp_ready, cdb_valid, cdb_mispredict;
  logic rf_we, st_go, flush;
  logic [1:0] disp_kind;
  logic [4:0] disp_dest, rf_addr;
  logic [2:0] disp_tag, cdb_tag, st_tag;
  logic [31:0] cdb_value, rf_data;

  spec_rob dut (
    .clk(clk), .rst_n(rst_n), .rs_avail(rs_avail), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_kind(disp_kind), .disp_dest(disp_dest),
    .disp_tag(disp_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value), .cdb_mispredict(cdb_mispredict), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_data(rf_data), .st_go(st_go), .st_tag(st_tag),
    .flush(flush)
  );

  int total = 0, bad = 0;
  bit m_v[8], m_r[8], m_m[8];
  int m_k[8], m_d[8];
  logic [31:0] m_val[8];
  int m_h = 0, m_t = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    int h, cnt, tg;
    bit hv, efl, erf, est, com, erdy, cap;
    #0.2;
    h = m_h % 8;
    hv = m_v[h] && m_r[h];
    efl = hv && m_k[h] == 2 && m_m[h];
    est = hv && m_k[h] == 1;
    erf = hv && m_k[h] != 1 && m_k[h] != 2;
    com = hv && !efl;
    cnt = (m_t - m_h + 16) % 16;
    erdy = rs_avail && !efl && (cnt < 8 || com);
    chk("R2", "disp_ready", disp_ready, erdy);
    chk("R2", "disp_tag", disp_tag, m_t % 8);
    chk("R7", "rf_we", rf_we, erf);
    if (erf) begin
      chk("R7", "rf_addr", rf_addr, m_d[h]);
      chk("R7", "rf_data", rf_data, m_val[h]);
    end
    chk("R8", "st_go", st_go, est);
    if (est) chk("R8", "st_tag", st_tag, h);
    chk("R10", "flush", flush, efl);
    tg = int'(cdb_tag);
    cap = cdb_valid && m_v[tg] && !m_r[tg];
    @(posedge clk);
    if (efl) begin
      for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_r[i] = 0; end
      m_h = 0; m_t = 0;
    end else begin
      if (com) begin m_v[h] = 0; m_h = (m_h + 1) % 16; end
      if (cap) begin m_r[tg] = 1; m_val[tg] = cdb_value; m_m[tg] = cdb_mispredict; end
      if (disp_valid && erdy) begin
        m_v[m_t % 8] = 1; m_r[m_t % 8] = 0; m_m[m_t % 8] = 0;
        m_k[m_t % 8] = int'(disp_kind); m_d[m_t % 8] = int'(disp_dest);
        m_t = (m_t + 1) % 16;
      end
    end
    @(negedge clk);
  endtask

  task automatic disp(int kind, int dest);
    disp_valid = 1; disp_kind = 2'(kind); disp_dest = 5'(dest);
    step();
    disp_valid = 0;
  endtask

  task automatic bcast(int tag, logic [31:0] v, bit m);
    cdb_valid = 1; cdb_tag = 3'(tag); cdb_value = v; cdb_mispredict = m;
    step();
    cdb_valid = 0; cdb_mispredict = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int ta, tb2, tc, td;
    rst_n = 0; rs_avail = 1; disp_valid = 0; disp_kind = 0; disp_dest = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_value = 0; cdb_mispredict = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #0.2;
    chk("R1", "reset disp_ready", disp_ready, 1);
    chk("R1", "reset disp_tag", disp_tag, 0);
    chk("R1", "reset commit idle", {rf_we, st_go, flush}, 0);
    idle(1);

    // in-order ALU commit, ignored broadcasts
    disp(0, 1); disp(0, 2); disp(0, 3);
    bcast(1, 32'h11, 0);
    #0.2 chk("R6", "younger ready waits", rf_we, 0);
    bcast(5, 32'h55, 0);
    #0.2 chk("R5", "free tag ignored", rf_we, 0);
    bcast(0, 32'hA0, 0);
    #0.2 chk("R7", "head write data", rf_data, 32'hA0);
    chk("R7", "head write addr", rf_addr, 1);
    bcast(2, 32'h22, 0);
    bcast(2, 32'h99, 0);
    #0.2 chk("R5", "duplicate ignored", rf_data, 32'h22);
    idle(1);

    // store then correctly predicted branch
    disp(1, 0); disp(2, 0);
    bcast(4, 32'h0, 0);
    bcast(3, 32'h0, 0);
    #0.2 chk("R8", "store tag", st_tag, 3);
    chk("R8", "store no rf write", rf_we, 0);
    step();
    #0.2 chk("R9", "branch retires quietly", {rf_we, st_go, flush}, 0);
    idle(1);

    // fill, full, full with retire
    for (int i = 0; i < 8; i++) disp(0, 10 + i);
    disp_valid = 1;
    #0.2 chk("R3", "full blocks dispatch", disp_ready, 0);
    step();
    disp_valid = 0;
    bcast(5, 32'h500, 0);
    disp_valid = 1; disp_dest = 31;
    #0.2 chk("R4", "full with retire accepts", disp_ready, 1);
    step();
    disp_valid = 0;
    for (int i = 0; i < 8; i++) bcast((6 + i) % 8, 32'h600 + i, 0);
    idle(10);

    // mispredicted branch flush
    ta = m_t % 8; disp(0, 4);
    tb2 = m_t % 8; disp(2, 0);
    tc = m_t % 8; disp(0, 5);
    td = m_t % 8; disp(0, 6);
    bcast(tc, 32'hC0, 0);
    bcast(ta, 32'hA1, 0);
    bcast(tb2, 32'h0, 1);
    disp_valid = 1; disp_kind = 0; disp_dest = 7;
    #0.2 chk("R10", "flush raised", flush, 1);
    chk("R10", "dispatch blocked in flush", disp_ready, 0);
    step();
    disp_valid = 0;
    #0.2 chk("R10", "tag restarts at 0", disp_tag, 0);
    bcast(td, 32'hD0, 0);
    bcast(tc, 32'hC1, 0);
    #0.2 chk("R10", "discarded entries stay silent", rf_we, 0);
    idle(1);

    // reservation station gate
    rs_avail = 0; disp_valid = 1;
    #0.2 chk("R11", "no station no ready", disp_ready, 0);
    step(); step();
    #0.2 chk("R11", "tag not consumed", disp_tag, 0);
    rs_avail = 1; disp_valid = 0;
    disp(0, 9);
    bcast(0, 32'h90, 0);
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule